// File: doc/BRIEF.md
# CAN Bus Self-Wake and Resynchronizer

This block sits beside a CAN controller and covers two moments around a stopped period. While the controller is stopped and self-wake was enabled when the stop began, the block watches the receive line. A falling edge, from recessive to dominant, raises a sticky wake flag. If the wake mask is also set, the flag drives an interrupt line so the system can restart the clocks.

Once the stop request is removed, the block keeps the controller off the bus. It releases the controller only after it has seen a run of consecutive recessive bit times. For this reason the frame that caused the wake is never received. The recessive run is counted on a bit-time tick that comes from outside the block. The raw receive level passes through an internal two-flop synchronizer.

Top module: `busWakeResync`

## Requirements
- R1: After reset, `wakeFlag`, `wakeIrq` and `busSynced` are all 0.
- R2: Self-wake is armed by the value of `selfWakeEn` sampled on the clock edge where `stopReq` first reads 1. Changing `selfWakeEn` later in the same stop has no effect on arming.
- R3: Dominant is 0 and recessive is 1. While armed and `stopReq` is 1, a 1-to-0 change on `rxIn` sets `wakeFlag`. The flag is visible after the third rising clock edge that follows the change. The first two edges pass through the synchronizer.
- R4: A falling edge on `rxIn` leaves `wakeFlag` at 0 when self-wake is not armed, and also when `stopReq` is 0.
- R5: `wakeIrq` is 1 only when `wakeFlag` is 1 and `wakeMaskEn` is 1. A working wake interrupt therefore needs both configuration bits.
- R6: A write-one pulse on `wakeFlagClr` clears `wakeFlag` on the next edge. If a new wake edge is detected on that same edge, the flag stays 1. Otherwise the flag holds its value.
- R7: `busSynced` is 0 whenever `stopReq` is 1. After `stopReq` falls, `busSynced` rises on the edge of the 11th consecutive `bitTick` at which the synchronized level is recessive.
- R8: The recessive run advances only on `bitTick` cycles. Any cycle with a dominant synchronized sample restarts the run from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Raw CAN receive level (0 dominant, 1 recessive) |
| bitTick | input | 1 | One-cycle pulse per nominal bit time |
| selfWakeEn | input | 1 | Self-wake enable configuration bit |
| wakeMaskEn | input | 1 | Wake interrupt mask (1 enables the interrupt) |
| stopReq | input | 1 | Stop request currently active |
| wakeFlagClr | input | 1 | Write-one-to-clear pulse for the wake flag |
| wakeFlag | output | 1 | Sticky wake status flag |
| wakeIrq | output | 1 | Wake interrupt line |
| busSynced | output | 1 | Controller synchronized to an idle bus |

## Verification
A change on `rxIn` reaches `wakeFlag` after three rising edges. The bench therefore drives `rxIn` on a falling edge and samples the flag two falling edges later, where it must still be 0. It samples again at the third falling edge, where it must be 1. `wakeIrq` has no register of its own, so it is checked in the same sample as the flag. A clear pulse, and `busSynced` after a qualifying tick, each take effect on the next rising edge. The bench holds each pulse for exactly one cycle and samples at the following falling edge. It checks `busSynced` one tick before the run completes and again on the tick that completes it.

// File: rtl/busWakePkg.sv
package busWakePkg;
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic cntClr;
    logic cntInc;
  } wakeStrobes_t;
endpackage

// File: rtl/busWakeDatapath.sv
module busWakeDatapath
  import busWakePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 11
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxIn,
  input  wakeStrobes_t strb,
  output logic         rxLevel,
  output logic         fallEdge,
  output logic         cntLast,
  output logic         wakeFlag
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rxPrev;
  logic [CNT_W-1:0]       runCnt;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[gi] <= 1'b1;
          else       syncChain[gi] <= rxIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[gi] <= 1'b1;
          else       syncChain[gi] <= syncChain[gi-1];
      end
    end
  endgenerate

  assign rxLevel  = syncChain[SYNC_STAGES-1];
  assign fallEdge = rxPrev & ~rxLevel;
  assign cntLast  = (runCnt == CNT_W'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev   <= 1'b1;
      runCnt   <= '0;
      wakeFlag <= 1'b0;
    end else begin
      rxPrev <= rxLevel;
      if (strb.cntClr)      runCnt <= '0;
      else if (strb.cntInc) runCnt <= runCnt + 1'b1;
      if (strb.setFlag)      wakeFlag <= 1'b1;
      else if (strb.clrFlag) wakeFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/busWakeControl.sv
module busWakeControl
  import busWakePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         selfWakeEn,
  input  logic         stopReq,
  input  logic         wakeFlagClr,
  input  logic         bitTick,
  input  logic         rxLevel,
  input  logic         fallEdge,
  input  logic         cntLast,
  output wakeStrobes_t strb,
  output logic         busSynced
);
  logic stopPrev;
  logic armed;
  logic stopEntry;

  assign stopEntry = stopReq & ~stopPrev;

  always_comb begin
    strb.setFlag = armed & stopReq & fallEdge;
    strb.clrFlag = wakeFlagClr;
    strb.cntClr  = stopReq | ~rxLevel | busSynced;
    strb.cntInc  = bitTick & rxLevel & ~stopReq & ~busSynced;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopPrev  <= 1'b0;
      armed     <= 1'b0;
      busSynced <= 1'b0;
    end else begin
      stopPrev <= stopReq;
      if (!stopReq)       armed <= 1'b0;
      else if (stopEntry) armed <= selfWakeEn;
      if (stopReq)                         busSynced <= 1'b0;
      else if (strb.cntInc && cntLast)     busSynced <= 1'b1;
    end
  end
endmodule

// File: rtl/busWakeResync.sv
module busWakeResync
  import busWakePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  input  logic bitTick,
  input  logic selfWakeEn,
  input  logic wakeMaskEn,
  input  logic stopReq,
  input  logic wakeFlagClr,
  output logic wakeFlag,
  output logic wakeIrq,
  output logic busSynced
);
  wakeStrobes_t strb;
  logic rxLevel;
  logic fallEdge;
  logic cntLast;

  busWakeControl uCtrl (
    .clk(clk), .rstN(rstN), .selfWakeEn(selfWakeEn), .stopReq(stopReq),
    .wakeFlagClr(wakeFlagClr), .bitTick(bitTick), .rxLevel(rxLevel),
    .fallEdge(fallEdge), .cntLast(cntLast), .strb(strb), .busSynced(busSynced)
  );

  busWakeDatapath #(.SYNC_STAGES(SYNC_STAGES), .RUN_LEN(RUN_LEN)) uData (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strb(strb), .rxLevel(rxLevel),
    .fallEdge(fallEdge), .cntLast(cntLast), .wakeFlag(wakeFlag)
  );

  assign wakeIrq = wakeFlag & wakeMaskEn;
endmodule

// File: rtl/busWakeResync_chk.sv
module busWakeResync_chk (
  input logic clk,
  input logic rstN,
  input logic rxIn,
  input logic bitTick,
  input logic selfWakeEn,
  input logic wakeMaskEn,
  input logic stopReq,
  input logic wakeFlagClr,
  input logic wakeFlag,
  input logic wakeIrq,
  input logic busSynced
);
  AST_FLAG_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(stopReq)); // R4
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !wakeMaskEn |-> !wakeIrq); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFlag && !wakeFlagClr) |=> wakeFlag); // R6
  AST_NO_SYNC_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !busSynced); // R7
  AST_SYNC_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busSynced) |-> $past(bitTick)); // R8
endmodule

bind busWakeResync busWakeResync_chk uChk (.*);

// File: tb/busWakeResync_test.sv
module busWakeResync_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic bitTick = 1'b0;
  logic selfWakeEn = 1'b0;
  logic wakeMaskEn = 1'b0;
  logic stopReq = 1'b0;
  logic wakeFlagClr = 1'b0;
  logic wakeFlag, wakeIrq, busSynced;
  int   nRun = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  busWakeResync uut (.*);

  // {selfWakeEn at entry, selfWakeEn later in stop, wakeMaskEn, expected flag}
  localparam logic [3:0] VEC [4] = '{4'b1111, 4'b1001, 4'b0110, 4'b0010};

  task automatic chk(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; rxIn = 1'b1; bitTick = 1'b0; stopReq = 1'b0;
    wakeFlagClr = 1'b0; selfWakeEn = 1'b0; wakeMaskEn = 1'b0;
    cyc(2); rstN = 1'b1; cyc(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1; cyc(1); bitTick = 1'b0; cyc(1);
    end
  endtask

  initial begin
    cyc(1);
    doReset();
    chk("R1 flag", wakeFlag, 1'b0);
    chk("R1 irq", wakeIrq, 1'b0);
    chk("R1 synced", busSynced, 1'b0);

    for (int v = 0; v < 4; v++) begin
      doReset();
      selfWakeEn = VEC[v][3]; wakeMaskEn = VEC[v][1];
      stopReq = 1'b1; cyc(1);
      selfWakeEn = VEC[v][2]; cyc(1);
      rxIn = 1'b0; cyc(2);
      chk("R3 latency", wakeFlag, 1'b0);
      cyc(1);
      chk("R2 R3 R4 flag", wakeFlag, VEC[v][0]);
      chk("R5 irq", wakeIrq, VEC[v][0] & VEC[v][1]);
    end

    // R4: edge while not stopped
    doReset(); selfWakeEn = 1'b1; wakeMaskEn = 1'b1;
    rxIn = 1'b0; cyc(4);
    chk("R4 not stopped", wakeFlag, 1'b0);

    // R6: clear, then clear coinciding with a new edge
    doReset(); selfWakeEn = 1'b1; wakeMaskEn = 1'b0; stopReq = 1'b1; cyc(1);
    rxIn = 1'b0; cyc(3);
    chk("R6 set", wakeFlag, 1'b1);
    chk("R5 masked", wakeIrq, 1'b0);
    rxIn = 1'b1; cyc(4);
    chk("R6 held", wakeFlag, 1'b1);
    wakeFlagClr = 1'b1; cyc(1); wakeFlagClr = 1'b0;
    chk("R6 clear", wakeFlag, 1'b0);
    cyc(1);
    rxIn = 1'b0; cyc(2);
    wakeFlagClr = 1'b1; cyc(1); wakeFlagClr = 1'b0;
    chk("R6 set wins", wakeFlag, 1'b1);

    // R7/R8: resynchronization after stop
    rxIn = 1'b1; cyc(3);
    ticks(12);
    chk("R7 no sync in stop", busSynced, 1'b0);
    stopReq = 1'b0; cyc(30);
    chk("R8 no ticks no sync", busSynced, 1'b0);
    ticks(5);
    rxIn = 1'b0; cyc(3); ticks(3); rxIn = 1'b1; cyc(3);
    ticks(10);
    chk("R8 dominant restarts run", busSynced, 1'b0);
    bitTick = 1'b1; cyc(1); bitTick = 1'b0;
    chk("R7 synced on 11th", busSynced, 1'b1);
    chk("R6 flag survives stop exit", wakeFlag, 1'b1);
    stopReq = 1'b1; cyc(1);
    chk("R7 drop on stop", busSynced, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule